// File: doc/BRIEF.md
# Debug-Pin Qualifier with Wake and Test-Port Unlock

This block watches one active-low debug pin, `dbg_pin_n`, and turns it into three separate actions. A low level held long enough in the system-clock domain raises a one-cycle debug-entry request to the processor. A shorter low level, counted on the test clock while the test access port sits in its reset state, sets a sticky enable that opens the debug logic to the test port. During low-power operation the same pin also drives a clock-restart signal with no clock at all. Once the clocks run again, a qualified low level produces a wake-into-debug pulse.

Each clock domain has its own two-flop synchroniser on the pin. A low count in each domain restarts whenever the synchronised pin reads high. The sticky enable is cleared only by power-on reset or test reset. The processor side is reset by power-on reset only.

Top module: `dbg_pin_ctrl`

## Requirements
- R1: When `dbg_pin_n` is 0 (asserted) at three consecutive rising `sysclk` edges, with `por_n`=1, `in_debug`=0 and `low_power`=0, `dbg_req` is 1 during the cycle that follows the second rising edge after the third low sample. A low level that covers only one or two rising edges produces no request.
- R2: While `por_n` is 0, the pin has no effect on `dbg_req`, `wake_dbg` or `tap_dbg_en`, which all stay 0. A pin that is held low into reset produces no request once reset is released, provided the pin goes high before the release.
- R3: While `in_debug` is 1, a low pin produces no `dbg_req`. A low level that began or continued during debug must first return high before a new request can qualify after `in_debug` falls.
- R4: `tap_dbg_en` becomes 1 two rising `tclk` edges after the second of two consecutive rising `tclk` edges at which `dbg_pin_n` is 0 while `tap_in_reset` is 1 and both `por_n` and `trst_n` are 1. A single low `tclk` sample, or any low level while `tap_in_reset` is 0, leaves it 0.
- R5: Once `tap_dbg_en` is 1, it stays 1 whatever the pin or `tap_in_reset` do. It returns to 0 only when `trst_n` or `por_n` goes low.
- R6: `clk_wake` is 1 exactly while `low_power` is 1 and `dbg_pin_n` is 0. It follows the pin with no clock edge. It is 0 whenever `low_power` is 0.
- R7: While `low_power` is 1, a low level meeting the three-edge rule of R1 gives a one-cycle `wake_dbg` pulse with the same latency, and no `dbg_req`. Two low edges give no pulse.
- R8: `dbg_req` is a single-cycle pulse, issued at most once for each continuous low period of the pin, however long that period lasts.
- R9: One low level of the pin, taken while `tap_in_reset` is 1 and neither reset is asserted, can both set `tap_dbg_en` and issue a `dbg_req`. Neither action blocks the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysclk | input | 1 | System clock |
| tclk | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| trst_n | input | 1 | Test reset, active low, asynchronous |
| dbg_pin_n | input | 1 | Debug pin, active low, asynchronous to both clocks |
| tap_in_reset | input | 1 | High while the test port is in its reset state |
| in_debug | input | 1 | High while the processor is in debug mode |
| low_power | input | 1 | High while the chip is in low-power mode |
| dbg_req | output | 1 | One-cycle debug-entry request, `sysclk` domain |
| tap_dbg_en | output | 1 | Sticky test-port debug access enable, `tclk` domain |
| clk_wake | output | 1 | Combinational clock-restart request |
| wake_dbg | output | 1 | One-cycle wake-into-debug pulse, `sysclk` domain |

## Verification
The debug-entry request and the test-port unlock can both result from the same low excursion of the pin. They are counted on different clocks and can assert in overlapping cycles. The bench provokes this by holding `tap_in_reset` high and driving the pin low across two test-clock edges, which also spans six system-clock edges. It then requires `tap_dbg_en` to rise exactly on its expected test-clock edge and exactly one `dbg_req` pulse to be counted for that excursion.

// File: rtl/dbg_pin_ctrl.sv
module dbg_pin_ctrl #(
  parameter int SYS_LOW = 3,
  parameter int TCK_LOW = 2
) (
  input  logic sysclk,
  input  logic tclk,
  input  logic por_n,
  input  logic trst_n,
  input  logic dbg_pin_n,
  input  logic tap_in_reset,
  input  logic in_debug,
  input  logic low_power,
  output logic dbg_req,
  output logic tap_dbg_en,
  output logic clk_wake,
  output logic wake_dbg
);
  localparam int SW = $clog2(SYS_LOW + 1);
  localparam int TW = $clog2(TCK_LOW + 1);

  // system-clock side
  logic [1:0]    s_sync;
  logic [SW-1:0] s_cnt;
  logic          armed;
  wire           s_low = ~s_sync[1];
  wire           s_hit = s_low && armed && (s_cnt == SW'(SYS_LOW - 1));

  always_ff @(posedge sysclk or negedge por_n)
    if (!por_n) s_sync <= 2'b11;
    else        s_sync <= {s_sync[0], dbg_pin_n};

  always_ff @(posedge sysclk or negedge por_n)
    if (!por_n) begin
      s_cnt    <= '0;
      armed    <= 1'b1;
      dbg_req  <= 1'b0;
      wake_dbg <= 1'b0;
    end else begin
      if (!s_low)                      s_cnt <= '0;
      else if (s_cnt != SW'(SYS_LOW))  s_cnt <= s_cnt + 1'b1;

      if (!s_low)                                     armed <= 1'b1;
      else if (s_hit || (in_debug && !low_power))     armed <= 1'b0;

      dbg_req  <= s_hit && !low_power && !in_debug;
      wake_dbg <= s_hit && low_power;
    end

  // test-clock side
  wire           t_rst_n = por_n & trst_n;
  logic [1:0]    t_sync;
  logic [TW-1:0] t_cnt;
  wire           t_low = ~t_sync[1] & tap_in_reset;

  always_ff @(posedge tclk or negedge t_rst_n)
    if (!t_rst_n) t_sync <= 2'b11;
    else          t_sync <= {t_sync[0], dbg_pin_n};

  always_ff @(posedge tclk or negedge t_rst_n)
    if (!t_rst_n) begin
      t_cnt      <= '0;
      tap_dbg_en <= 1'b0;
    end else begin
      if (!t_low)                      t_cnt <= '0;
      else if (t_cnt != TW'(TCK_LOW))  t_cnt <= t_cnt + 1'b1;
      if (t_low && t_cnt == TW'(TCK_LOW - 1)) tap_dbg_en <= 1'b1;
    end

  // clock-free wake path
  assign clk_wake = low_power & ~dbg_pin_n;
endmodule

// File: rtl/dbg_pin_ctrl_chk.sv
module dbg_pin_ctrl_chk (
  input logic sysclk,
  input logic tclk,
  input logic por_n,
  input logic trst_n,
  input logic dbg_pin_n,
  input logic tap_in_reset,
  input logic in_debug,
  input logic low_power,
  input logic dbg_req,
  input logic tap_dbg_en,
  input logic clk_wake,
  input logic wake_dbg
);
  // R1: a request needs three low pin samples, seen through the synchroniser
  p_req_qual_r1: assert property (@(posedge sysclk) disable iff (!por_n)
    dbg_req |-> (!$past(dbg_pin_n, 3) && !$past(dbg_pin_n, 4) && !$past(dbg_pin_n, 5)));

  p_no_req_in_dbg_r3: assert property (@(posedge sysclk) disable iff (!por_n)
    dbg_req |-> !$past(in_debug));

  p_sticky_r5: assert property (@(posedge tclk) disable iff (!por_n || !trst_n)
    tap_dbg_en |=> tap_dbg_en);

  p_wake_lp_r7: assert property (@(posedge sysclk) disable iff (!por_n)
    wake_dbg |-> ($past(low_power) && !dbg_req));

  p_single_pulse_r8: assert property (@(posedge sysclk) disable iff (!por_n)
    dbg_req |=> !dbg_req);

  p_wake_gate_r6: assert property (@(posedge sysclk) disable iff (!por_n)
    clk_wake |-> (low_power && !dbg_pin_n));
endmodule

bind dbg_pin_ctrl dbg_pin_ctrl_chk u_chk (.*);

// File: tb/dbg_pin_ctrl_test.sv
module dbg_pin_ctrl_test;
  logic sysclk = 0, tclk = 0;
  logic por_n = 0, trst_n = 0, dbg_pin_n = 1;
  logic tap_in_reset = 0, in_debug = 0, low_power = 0;
  logic dbg_req, tap_dbg_en, clk_wake, wake_dbg;
  int   vecs = 0, miss = 0;
  int   req_cnt = 0, wake_cnt = 0;

  always #10 sysclk = ~sysclk;
  always #30 tclk   = ~tclk;

  dbg_pin_ctrl uut (.*);

  always @(negedge sysclk) begin
    if (dbg_req)  req_cnt++;
    if (wake_dbg) wake_cnt++;
  end

  localparam int NV = 6;
  localparam int VLEN [NV] = '{1, 2, 3, 4, 9, 3};
  localparam int VEXP [NV] = '{0, 0, 1, 1, 1, 1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic low_for(input int n);
    @(negedge sysclk) dbg_pin_n = 0;
    repeat (n) @(negedge sysclk);
    dbg_pin_n = 1;
    repeat (6) @(negedge sysclk);
  endtask

  initial begin
    #2_000_000;
    miss++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    int b, w;
    repeat (4) @(negedge sysclk);
    chk(!dbg_req && !tap_dbg_en && !wake_dbg && !clk_wake, "R2 reset state",
        {dbg_req, tap_dbg_en, wake_dbg, clk_wake}, 0);
    // R2: low pin inside reset
    dbg_pin_n = 0;
    repeat (8) @(negedge sysclk);
    chk(req_cnt == 0 && !tap_dbg_en, "R2 ignored in reset", req_cnt, 0);
    dbg_pin_n = 1;
    repeat (2) @(negedge sysclk);
    por_n = 1; trst_n = 1;
    repeat (8) @(negedge sysclk);
    chk(req_cnt == 0, "R2 no request after release", req_cnt, 0);

    // R1/R8 vector table
    for (int i = 0; i < NV; i++) begin
      b = req_cnt;
      low_for(VLEN[i]);
      chk(req_cnt - b == VEXP[i], $sformatf("R1 R8 low for %0d edges", VLEN[i]),
          req_cnt - b, VEXP[i]);
    end

    // R1 exact latency, R8 single pulse
    b = req_cnt;
    @(negedge sysclk) dbg_pin_n = 0;
    repeat (4) @(negedge sysclk);
    chk(dbg_req == 0, "R1 not yet", dbg_req, 0);
    @(negedge sysclk);
    chk(dbg_req == 1, "R1 latency", dbg_req, 1);
    @(negedge sysclk);
    chk(dbg_req == 0, "R8 one cycle", dbg_req, 0);
    repeat (10) @(negedge sysclk);
    chk(req_cnt - b == 1, "R8 once per low period", req_cnt - b, 1);
    dbg_pin_n = 1;
    repeat (4) @(negedge sysclk);

    // R3 suppression in debug and re-arm
    in_debug = 1;
    b = req_cnt;
    low_for(6);
    chk(req_cnt == b, "R3 suppressed in debug", req_cnt - b, 0);
    @(negedge sysclk) dbg_pin_n = 0;
    repeat (4) @(negedge sysclk);
    in_debug = 0;
    repeat (8) @(negedge sysclk);
    chk(req_cnt == b, "R3 needs high after debug", req_cnt - b, 0);
    dbg_pin_n = 1;
    repeat (4) @(negedge sysclk);
    low_for(3);
    chk(req_cnt - b == 1, "R3 re-armed", req_cnt - b, 1);

    // R6 clock-free path
    @(negedge sysclk);
    dbg_pin_n = 0; #1;
    chk(clk_wake == 0, "R6 gated off", clk_wake, 0);
    dbg_pin_n = 1; low_power = 1; #1;
    chk(clk_wake == 0, "R6 pin high", clk_wake, 0);
    dbg_pin_n = 0; #1;
    chk(clk_wake == 1, "R6 immediate", clk_wake, 1);
    dbg_pin_n = 1; #1;
    chk(clk_wake == 0, "R6 released", clk_wake, 0);

    // R7 wake sequence
    b = req_cnt; w = wake_cnt;
    low_for(2);
    chk(wake_cnt == w, "R7 two edges rejected", wake_cnt - w, 0);
    low_for(3);
    chk(wake_cnt - w == 1, "R7 wake pulse", wake_cnt - w, 1);
    chk(req_cnt == b, "R7 no debug request", req_cnt - b, 0);
    low_power = 0;

    // R4 test-port enable
    @(posedge tclk) #1 dbg_pin_n = 0;
    repeat (3) @(posedge tclk);
    #1 dbg_pin_n = 1;
    repeat (4) @(posedge tclk);
    #1 chk(tap_dbg_en == 0, "R4 port not in reset", tap_dbg_en, 0);
    tap_in_reset = 1;
    @(posedge tclk) #1 dbg_pin_n = 0;
    @(posedge tclk) #1 dbg_pin_n = 1;
    repeat (4) @(posedge tclk);
    #1 chk(tap_dbg_en == 0, "R4 one edge rejected", tap_dbg_en, 0);

    // R9 same excursion sets enable and requests debug
    b = req_cnt;
    @(posedge tclk) #1 dbg_pin_n = 0;
    @(posedge tclk);
    @(posedge tclk) #1 dbg_pin_n = 1;
    @(posedge tclk) #1 chk(tap_dbg_en == 0, "R4 not yet", tap_dbg_en, 0);
    @(posedge tclk) #1 chk(tap_dbg_en == 1, "R4 R9 enable set", tap_dbg_en, 1);
    repeat (6) @(negedge sysclk);
    chk(req_cnt - b == 1, "R9 request too", req_cnt - b, 1);

    // R5 sticky and clears
    tap_in_reset = 0;
    low_for(8);
    chk(tap_dbg_en == 1, "R5 sticky", tap_dbg_en, 1);
    trst_n = 0; #5;
    chk(tap_dbg_en == 0, "R5 cleared by test reset", tap_dbg_en, 0);
    repeat (2) @(posedge tclk);
    #1 trst_n = 1;
    tap_in_reset = 1;
    @(posedge tclk) #1 dbg_pin_n = 0;
    repeat (4) @(posedge tclk);
    #1 dbg_pin_n = 1;
    chk(tap_dbg_en == 1, "R5 set again", tap_dbg_en, 1);
    tap_in_reset = 0;
    @(negedge sysclk) por_n = 0; #5;
    chk(tap_dbg_en == 0, "R5 cleared by power-on reset", tap_dbg_en, 0);
    repeat (3) @(negedge sysclk);
    por_n = 1;
    repeat (3) @(negedge sysclk);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule